// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

The block gathers eight interrupt request lines into one interrupt signal for a host processor. It keeps a pending-request register, an in-service register and a mask register, one bit per level. It picks a winner by fixed or rotating priority and accepts each line as edge- or level-sensitive. The host answers the interrupt with two acknowledge pulses. The first pulse moves the winning level from pending to in-service. The second pulse returns a vector byte formed from a programmable base and the level number.

A level leaves in-service when the host writes an end-of-interrupt command, or at the second acknowledge pulse when automatic clearing is enabled. A lower level that is in service does not hold back a higher one, so handlers can nest. If the request disappears before the first pulse, the controller answers with a spurious vector for level 7.

A small register write port sets the mode, the mask and the vector base, and carries the command.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, int_o and vec_valid_o are low and vec_o is 0x00. Every input is masked. The controller is in edge mode with fixed priority and explicit end-of-interrupt.
- R2: Write addresses:
  - Address 0 is control: bit0 selects level mode, bit1 selects automatic end-of-interrupt, bit2 selects rotating priority.
  - Address 1 is the mask: bit i set masks input i.
  - Address 2 is the vector base: only bits 7:3 are kept.
  - Address 3 is the command: bit0 set issues a non-specific end-of-interrupt.
- R3: In edge mode a request is latched one clock after its input goes from low to high. A line held high after its request was acknowledged raises no new request. In both modes a pending bit clears one clock after its input goes low.
- R4: In level mode an input that is high is pending one clock later. It stays pending for as long as it is high, also after it has been acknowledged.
- R5: int_o is high exactly when some unmasked pending level has priority over every in-service level. A masked input never raises int_o. int_o follows the stored state with no further delay.
- R6: In fixed priority, level 0 is the highest and level 7 the lowest.
- R7: In rotating priority, the level cleared by an end-of-interrupt becomes the lowest and the next level up becomes the highest. After reset, level 7 is the lowest.
- R8: The first inta_i pulse sets the in-service bit of the winner and clears its pending bit. In the cycle after the second pulse, vec_valid_o is high for one cycle and vec_o = {base[7:3], level}.
- R9: If nothing qualifies at the first pulse, the vector after the second pulse carries level 7 and the in-service register is left unchanged.
- R10: A non-specific end-of-interrupt clears the highest-priority in-service bit. While a level is in service, only higher levels raise int_o.
- R11: With automatic end-of-interrupt, the in-service bit is cleared at the second pulse, so equal and lower levels can be served next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, bit i is level i |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_o | output | 1 | Interrupt request to the host |
| vec_valid_o | output | 1 | Vector byte valid, one cycle |
| vec_o | output | 8 | Vector byte, held until the next one |

## Verification
A corrupt pending or in-service bit shows on int_o in the same cycle it is stored. int_o then rises while a higher level should be blocking it, or stays low after an end-of-interrupt. A wrong rotation pointer or resolver order shows only at the next vector, as a wrong level in vec_o[2:0]. Because of that, the scenarios raise several levels at once and read the vector. A lost or doubled in-service bit appears one end-of-interrupt later, when a level that should be released stays blocked.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int unsigned CFG_AW = 2;

  localparam logic [CFG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_MASK = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_BASE = 2'd2;
  localparam logic [CFG_AW-1:0] ADDR_CMD  = 2'd3;

  typedef struct packed {
    logic rotate;
    logic auto_eoi;
    logic level;
  } ctrl_t;

  typedef enum logic {
    ACK_IDLE,
    ACK_SECOND
  } ack_st_e;
endpackage

// File: rtl/pic8_req_latch.sv
module pic8_req_latch #(
  parameter int unsigned N_LVL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_i,
  input  logic             level_mode_i,
  input  logic [N_LVL-1:0] clr_i,
  output logic [N_LVL-1:0] irr_o
);
  logic [N_LVL-1:0] irq_q;
  logic [N_LVL-1:0] irr_q;
  logic [N_LVL-1:0] set_req;

  // an edge arms the bit; level mode re-arms every cycle the line is high
  assign set_req = {N_LVL{level_mode_i}} | ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= irq_i & ((irr_q & ~clr_i) | set_req);
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/pic8_resolver.sv
// N_LVL must be a power of two: level indices wrap in LW bits.
module pic8_resolver #(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned LW = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] bits_i,
  input  logic [LW-1:0]    low_i,
  output logic             found_o,
  output logic [LW-1:0]    lvl_o,
  output logic [LW-1:0]    rank_o
);
  logic [LW-1:0] idx;

  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    rank_o  = '1;
    idx     = '0;
    // walk from lowest to highest priority so the last hit wins
    for (int k = N_LVL - 1; k >= 0; k--) begin
      idx = low_i + LW'(k + 1);
      if (bits_i[idx]) begin
        found_o = 1'b1;
        lvl_o   = idx;
        rank_o  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/pic8_ack_fsm.sv
module pic8_ack_fsm
  import pic8_pkg::*;
#(
  parameter int unsigned N_LVL  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LW = $clog2(N_LVL),
  localparam int unsigned BW = DATA_W - LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_i,
  input  logic              hit_i,
  input  logic [LW-1:0]     win_i,
  input  logic [BW-1:0]     base_i,
  output logic              idle_o,
  output logic              take_o,
  output logic              fin_o,
  output logic [LW-1:0]     fin_lvl_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o
);
  ack_st_e           st_q;
  logic [LW-1:0]     lvl_q;
  logic              spur_q;
  logic              vv_q;
  logic [DATA_W-1:0] vec_q;

  assign idle_o    = (st_q == ACK_IDLE);
  assign take_o    = inta_i & idle_o & hit_i;
  assign fin_o     = inta_i & ~idle_o & ~spur_q;
  assign fin_lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ACK_IDLE;
      lvl_q  <= '1;
      spur_q <= 1'b0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      vv_q <= 1'b0;
      if (inta_i) begin
        if (idle_o) begin
          st_q   <= ACK_SECOND;
          lvl_q  <= hit_i ? win_i : '1;
          spur_q <= ~hit_i;
        end else begin
          st_q  <= ACK_IDLE;
          vv_q  <= 1'b1;
          vec_q <= {base_i, lvl_q};
        end
      end
    end
  end

  assign vec_valid_o = vv_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter int unsigned N_LVL  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LVL-1:0]  irq_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam int unsigned LW = $clog2(N_LVL);
  localparam int unsigned BW = DATA_W - LW;

  ctrl_t            ctrl_q;
  logic [N_LVL-1:0] mask_q;
  logic [BW-1:0]    base_q;
  logic [N_LVL-1:0] isr_q;
  logic [LW-1:0]    low_q;

  logic [N_LVL-1:0] irr_q;
  logic [N_LVL-1:0] pend;
  logic [LW-1:0]    low_eff;
  logic             p_found, i_found;
  logic [LW-1:0]    p_lvl, i_lvl, p_rank, i_rank;
  logic             hit;
  logic             ack_idle, take, fin;
  logic [LW-1:0]    fin_lvl;
  logic             eoi;
  logic             auto_clr;
  logic [N_LVL-1:0] isr_set, isr_clr, irr_clr;

  assign low_eff = ctrl_q.rotate ? low_q : '1;
  assign pend    = irr_q & ~mask_q;

  pic8_req_latch #(.N_LVL(N_LVL)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .level_mode_i(ctrl_q.level),
    .clr_i       (irr_clr),
    .irr_o       (irr_q)
  );

  pic8_resolver #(.N_LVL(N_LVL)) u_pend_res (
    .bits_i (pend),
    .low_i  (low_eff),
    .found_o(p_found),
    .lvl_o  (p_lvl),
    .rank_o (p_rank)
  );

  pic8_resolver #(.N_LVL(N_LVL)) u_isr_res (
    .bits_i (isr_q),
    .low_i  (low_eff),
    .found_o(i_found),
    .lvl_o  (i_lvl),
    .rank_o (i_rank)
  );

  // a pending level must outrank every level in service
  assign hit   = p_found & (~i_found | (p_rank < i_rank));
  assign int_o = hit;

  pic8_ack_fsm #(.N_LVL(N_LVL), .DATA_W(DATA_W)) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inta_i     (inta_i),
    .hit_i      (hit),
    .win_i      (p_lvl),
    .base_i     (base_q),
    .idle_o     (ack_idle),
    .take_o     (take),
    .fin_o      (fin),
    .fin_lvl_o  (fin_lvl),
    .vec_valid_o(vec_valid_o),
    .vec_o      (vec_o)
  );

  assign eoi      = cfg_we_i & (cfg_addr_i == ADDR_CMD) & cfg_wdata_i[0];
  assign auto_clr = fin & ctrl_q.auto_eoi;

  assign irr_clr = take ? (N_LVL'(1) << p_lvl) : '0;
  assign isr_set = take ? (N_LVL'(1) << p_lvl) : '0;
  assign isr_clr = ((eoi & i_found) ? (N_LVL'(1) << i_lvl)   : '0)
                 | (auto_clr        ? (N_LVL'(1) << fin_lvl) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      low_q <= '1;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (ctrl_q.rotate) begin
        if (eoi & i_found)  low_q <= i_lvl;
        else if (auto_clr)  low_q <= fin_lvl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '1;
      base_q <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        ADDR_CTRL: ctrl_q <= cfg_wdata_i[2:0];
        ADDR_MASK: mask_q <= cfg_wdata_i[N_LVL-1:0];
        ADDR_BASE: base_q <= cfg_wdata_i[DATA_W-1:LW];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
  parameter int unsigned N_LVL  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LW = $clog2(N_LVL),
  localparam int unsigned BW = DATA_W - LW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inta_i,
  input logic              int_o,
  input logic              vec_valid_o,
  input logic [DATA_W-1:0] vec_o,
  input logic [N_LVL-1:0]  pend_i,
  input logic [N_LVL-1:0]  isr_i,
  input logic [BW-1:0]     base_i,
  input logic              idle_i,
  input logic              eoi_i
);
  p_int_needs_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (pend_i != '0));

  p_vec_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  p_vec_second_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ($past(inta_i) && !$past(idle_i)));

  p_vec_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[DATA_W-1:LW] == $past(base_i)));

  p_take_sets_isr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && idle_i && int_o && !eoi_i) |=>
      ($countones(isr_i) == $countones($past(isr_i)) + 1));

  p_spurious_keeps_isr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && idle_i && !int_o && !eoi_i) |=> (isr_i == $past(isr_i)));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.N_LVL(N_LVL), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inta_i     (inta_i),
  .int_o      (int_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .pend_i     (pend),
  .isr_i      (isr_q),
  .base_i     (base_q),
  .idle_i     (ack_idle),
  .eoi_i      (eoi)
);

// File: tb/pic8_ctrl_test.sv
module pic8_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic       inta = 1'b0;
  logic       int_o;
  logic       vv;
  logic [7:0] vec;

  always #5 clk = ~clk;

  pic8_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wd), .inta_i(inta), .int_o(int_o), .vec_valid_o(vv), .vec_o(vec)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit [7:0] m_irr, m_isr, m_mask, m_prev, m_base, m_vec;
  bit       m_lvl, m_auto, m_rot, m_wait, m_spur, m_vv;
  int       m_low, m_sel;

  function automatic int prio(int l, int low);
    return (l - low - 1 + 16) % 8;
  endfunction

  function automatic int best(bit [7:0] v, int low);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || prio(i, low) < prio(b, low))) b = i;
    return b;
  endfunction

  function automatic bit m_hit();
    int lo = m_rot ? m_low : 7;
    int p = best(m_irr & ~m_mask, lo);
    int s = best(m_isr, lo);
    return (p >= 0) && (s < 0 || prio(p, lo) < prio(s, lo));
  endfunction

  task automatic m_reset();
    m_irr = '0; m_isr = '0; m_mask = 8'hFF; m_prev = '0; m_base = '0; m_vec = '0;
    m_lvl = 0; m_auto = 0; m_rot = 0; m_wait = 0; m_spur = 0; m_vv = 0;
    m_low = 7; m_sel = 7;
  endtask

  task automatic m_step();
    int lo, p, s, nlow;
    bit hit;
    bit [7:0] nirr, nisr;
    lo = m_rot ? m_low : 7;
    p = best(m_irr & ~m_mask, lo);
    s = best(m_isr, lo);
    hit = m_hit();
    nirr = m_irr; nisr = m_isr; nlow = m_low;
    m_vv = 0;
    if (inta) begin
      if (!m_wait) begin
        m_wait = 1;
        if (hit) begin nisr[p] = 1; nirr[p] = 0; m_sel = p; m_spur = 0; end
        else begin m_sel = 7; m_spur = 1; end
      end else begin
        m_wait = 0; m_vv = 1;
        m_vec = {m_base[7:3], 3'(m_sel)};
        if (m_auto && !m_spur) begin nisr[m_sel] = 0; if (m_rot) nlow = m_sel; end
      end
    end
    if (we && addr == 2'd3 && wd[0] && s >= 0) begin
      nisr[s] = 0;
      if (m_rot) nlow = s;
    end
    for (int i = 0; i < 8; i++) begin
      if (!irq[i]) nirr[i] = 0;
      else if (m_lvl || !m_prev[i]) nirr[i] = 1;
    end
    if (we) begin
      case (addr)
        2'd0: {m_rot, m_auto, m_lvl} = wd[2:0];
        2'd1: m_mask = wd;
        2'd2: m_base = wd;
        default: ;
      endcase
    end
    m_prev = irq; m_irr = nirr; m_isr = nisr; m_low = nlow;
  endtask

  always @(posedge clk) begin
    if (!rst_ni) m_reset();
    else m_step();
    #2;
    if (rst_ni && !done) begin
      check("R5 int_o vs model", int_o, m_hit());
      check("R8 vec_valid_o vs model", vv, m_vv);
      check("R8 vec_o vs model", vec, m_vec);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wd = d;
    @(negedge clk);
    we = 0; wd = '0;
  endtask

  task automatic eoi();
    wr(2'd3, 8'h01);
  endtask

  task automatic ack();
    inta = 1; tick(1); inta = 0; tick(1);
    inta = 1; tick(1); inta = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1;
    tick(1);
    check("R1 int_o after reset", int_o, 0);
    check("R1 vec_valid_o after reset", vv, 0);
    check("R1 vec_o after reset", vec, 8'h00);
    irq[0] = 1; tick(2);
    check("R1 reset mask blocks IR0", int_o, 0);
    irq[0] = 0; tick(1);

    wr(2'd2, 8'h20); wr(2'd1, 8'h00);

    // edge request and handshake
    irq[3] = 1; tick(1);
    check("R3 edge latched", int_o, 1);
    ack();
    check("R8 vec valid", vv, 1);
    check("R8 vector level 3", vec, 8'h23);
    tick(1);
    check("R8 int drops once in service", int_o, 0);
    eoi(); tick(1);
    check("R3 held line no new request", int_o, 0);
    irq = '0; tick(1);

    // fixed priority and blocking
    irq[5] = 1; irq[2] = 1; tick(1);
    ack();
    check("R6 level 2 beats 5", vec, 8'h22);
    check("R10 lower pending blocked", int_o, 0);
    eoi();
    check("R10 released after eoi", int_o, 1);
    ack();
    check("R6 then level 5", vec, 8'h25);
    eoi(); irq = '0; tick(1);

    // nesting
    irq[6] = 1; tick(1); ack();
    check("R10 vector 6", vec, 8'h26);
    irq[1] = 1; tick(1);
    check("R10 higher nests", int_o, 1);
    ack();
    check("R10 vector 1", vec, 8'h21);
    eoi();
    irq[7] = 1; tick(1);
    check("R10 eoi cleared only level 1", int_o, 0);
    eoi();
    check("R10 second eoi clears 6", int_o, 1);
    ack();
    check("R6 vector 7", vec, 8'h27);
    eoi(); irq = '0; tick(1);

    // spurious
    irq[4] = 1; tick(1);
    check("R9 request seen", int_o, 1);
    irq[4] = 0; tick(1);
    check("R3 drop clears pending", int_o, 0);
    ack();
    check("R9 spurious vector", vec, 8'h27);
    irq[7] = 1; tick(1);
    check("R9 no in-service set", int_o, 1);
    ack();
    check("R9 real level 7", vec, 8'h27);
    eoi(); irq = '0; tick(1);

    // mask
    wr(2'd1, 8'h04);
    irq[2] = 1; tick(2);
    check("R5 masked input silent", int_o, 0);
    wr(2'd1, 8'h00);
    check("R5 unmask shows pending", int_o, 1);
    ack();
    check("R2 mask write then vector 2", vec, 8'h22);
    eoi(); irq = '0; tick(1);

    // level mode
    wr(2'd0, 8'h01);
    irq[5] = 1; tick(1);
    check("R4 level pending", int_o, 1);
    ack();
    check("R4 vector 5", vec, 8'h25);
    check("R4 blocked while in service", int_o, 0);
    eoi();
    check("R4 still high re-requests", int_o, 1);
    irq[5] = 0; tick(1);
    check("R4 low clears", int_o, 0);
    wr(2'd0, 8'h00);

    // rotating priority
    wr(2'd0, 8'h04);
    irq[1] = 1; tick(1); ack();
    check("R7 vector 1", vec, 8'h21);
    eoi();
    irq[1] = 0; irq[0] = 1; irq[3] = 1; tick(1);
    ack();
    check("R7 level 3 above 0 after rotate", vec, 8'h23);
    eoi();
    ack();
    check("R7 then level 0", vec, 8'h20);
    eoi(); irq = '0; tick(1);
    wr(2'd0, 8'h00);

    // automatic end of interrupt
    wr(2'd0, 8'h02);
    irq[4] = 1; tick(1); ack();
    check("R11 vector 4", vec, 8'h24);
    irq[6] = 1; tick(1);
    check("R11 in-service cleared", int_o, 1);
    ack();
    check("R11 vector 6", vec, 8'h26);
    irq = '0; tick(2);
    wr(2'd0, 8'h00);

    // base low bits ignored
    wr(2'd2, 8'hA5);
    irq[1] = 1; tick(1); ack();
    check("R2 base upper bits only", vec, 8'hA1);
    eoi(); irq = '0; tick(2);

    done = 1;
    summary();
    $finish;
  end
endmodule